// File: doc/BRIEF.md
# Power-Up Strap Capture and Clock Frequency Selector

This block sits between the shared clock/strap pads of a clock generator and its synthesis core. At power-up the pads are inputs, and their levels choose the hardware frequency code, the reset-pin function and the 24/48 MHz choice. On the first clock edge after the power-up reset is released, the block samples the pads once and holds the values. After that the pads drive clocks, and later pad levels are ignored until the next power-up reset.

After capture, the block produces a 6-bit frequency index. The index comes either from the five latched hardware bits (zero-extended, so 32 entries) or from a 6-bit code written by software (64 entries). A software-override bit chooses between them. Any change of the index raises a one-cycle strobe, which lets the synthesis core step the frequency smoothly. The block also turns the per-output enable bits into run and high-impedance controls. A global tri-state bit overrides every individual enable.

The control path is a two-state machine. `ST_SAMPLE` is entered on reset and holds the pads as inputs, with every clock stopped. The transition `SAMPLE_TO_RUN` is taken on the first clock edge with reset released, and it captures the straps. `ST_RUN` keeps its state until the next reset.

Top module: `strap_fsel`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, `strap_sample` is 1. On that edge the pad levels are captured and `strap_sample` falls to 0.
- R2: During reset the latched outputs hold the open-pad defaults: `fs_latched`=5'b11001 (bit 0 is FS0), `mode_latched`=1, `sel_24m`=1 and `freq_index`=25.
- R3: After capture, changes on `pin_fs`, `pin_mode` and `pin_sel` have no effect on the latched outputs or on `freq_index` until the next reset.
- R4: With `sw_override`=1, `freq_index` equals the `sw_index` value seen at the previous clock edge, and all 64 codes are reachable.
- R5: With `sw_override`=0, `freq_index` is {1'b0, fs_latched}, so only indices 0 to 31 occur.
- R6: `sel_24m` reports the captured 24/48 pad level: 1 selects 24 MHz and 0 selects 48 MHz. `mode_latched` reports the captured mode pad.
- R7: In the run state with `tristate_all`=1, every bit of `clk_hiz` is 1 and every bit of `clk_run` is 0, whatever `out_enable` holds.
- R8: In the run state with `tristate_all`=0, `clk_run[i]` equals `out_enable[i]` and `clk_hiz` is all zero. An enable of 0 stops that output.
- R9: `index_changed` is 1 for exactly the cycle in which a new `freq_index` value first appears during run. The capture itself does not raise it.
- R10: While `strap_sample` is 1, `clk_run` and `clk_hiz` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-up reset, active low |
| pin_fs | input | 5 | Pad levels of the hardware frequency straps, bit 0 = FS0 |
| pin_mode | input | 1 | Pad level of the reset-pin-function strap |
| pin_sel | input | 1 | Pad level of the 24/48 MHz strap |
| sw_override | input | 1 | 1 = use software index, 0 = use latched straps |
| sw_index | input | 6 | Software frequency code |
| tristate_all | input | 1 | Global tri-state of all clock outputs |
| out_enable | input | 8 | Per-output enable, 1 = running |
| strap_sample | output | 1 | Pads held as inputs (capture pending) |
| fs_latched | output | 5 | Captured frequency straps |
| mode_latched | output | 1 | Captured mode strap |
| sel_24m | output | 1 | 1 = 24 MHz, 0 = 48 MHz on the shared output |
| freq_index | output | 6 | Active frequency-select code |
| index_changed | output | 1 | One-cycle strobe on index change |
| clk_run | output | 8 | Per-output run control |
| clk_hiz | output | 8 | Per-output high-impedance control |

## Verification
If the state machine stuck in `ST_SAMPLE`, `strap_sample` would still be high and every `clk_run` bit would still be zero one cycle after reset release. If the strap registers were reloaded during run, the pad toggles applied after capture would change `fs_latched` or `freq_index` at the next edge. A stale or missing selection register would put a wrong `freq_index` or a wrong `index_changed` value on the ports one cycle after the input changes. The bench checks each of these at that cycle.

// File: rtl/strap_pkg.sv
package strap_pkg;
    typedef enum logic {
        ST_SAMPLE = 1'b0,
        ST_RUN    = 1'b1
    } fsm_t;

    localparam int FS_W  = 5;
    localparam int IDX_W = 6;
    localparam logic [FS_W-1:0] FS_DEFAULT   = 5'b11001;
    localparam logic            MODE_DEFAULT = 1'b1;
    localparam logic            SEL_DEFAULT  = 1'b1;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [FS_W-1:0] pin_fs,
    input  logic            pin_mode,
    input  logic            pin_sel,
    output logic [FS_W-1:0] fs_q,
    output logic            mode_q,
    output logic            sel_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q   <= FS_DEFAULT;
            mode_q <= MODE_DEFAULT;
            sel_q  <= SEL_DEFAULT;
        end else if (capture) begin
            fs_q   <= pin_fs;
            mode_q <= pin_mode;
            sel_q  <= pin_sel;
        end
    end
endmodule

// File: rtl/fsel_mux.sv
module fsel_mux
    import strap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [FS_W-1:0]  load_fs,
    input  logic [FS_W-1:0]  hw_fs,
    input  logic             sw_override,
    input  logic [IDX_W-1:0] sw_index,
    output logic [IDX_W-1:0] idx_q,
    output logic             chg_q
);
    localparam int PAD_W = IDX_W - FS_W;

    logic [FS_W-1:0]  hw_pick;
    logic [IDX_W-1:0] idx_next;

    always_comb begin
        hw_pick  = load ? load_fs : hw_fs;
        idx_next = sw_override ? sw_index : {{PAD_W{1'b0}}, hw_pick};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= {{PAD_W{1'b0}}, FS_DEFAULT};
            chg_q <= 1'b0;
        end else if (load) begin
            idx_q <= idx_next;
            chg_q <= 1'b0;
        end else if (run) begin
            idx_q <= idx_next;
            chg_q <= (idx_next != idx_q);
        end else begin
            chg_q <= 1'b0;
        end
    end
endmodule

// File: rtl/out_gate.sv
module out_gate #(
    parameter int N_OUT = 8
) (
    input  logic             running,
    input  logic             tri_all,
    input  logic [N_OUT-1:0] enable,
    output logic [N_OUT-1:0] run_o,
    output logic [N_OUT-1:0] hiz_o
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        always_comb begin
            run_o[i] = running && !tri_all && enable[i];
            hiz_o[i] = running && tri_all;
        end
    end
endmodule

// File: rtl/strap_fsel.sv
module strap_fsel
    import strap_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FS_W-1:0]  pin_fs,
    input  logic             pin_mode,
    input  logic             pin_sel,
    input  logic             sw_override,
    input  logic [IDX_W-1:0] sw_index,
    input  logic             tristate_all,
    input  logic [N_OUT-1:0] out_enable,
    output logic             strap_sample,
    output logic [FS_W-1:0]  fs_latched,
    output logic             mode_latched,
    output logic             sel_24m,
    output logic [IDX_W-1:0] freq_index,
    output logic             index_changed,
    output logic [N_OUT-1:0] clk_run,
    output logic [N_OUT-1:0] clk_hiz
);
    fsm_t state_q, state_d;
    logic capture, running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SAMPLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        running = 1'b0;
        unique case (state_q)
            ST_SAMPLE: begin
                capture = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                running = 1'b1;
            end
        endcase
        strap_sample = capture;
    end

    strap_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .pin_fs   (pin_fs),
        .pin_mode (pin_mode),
        .pin_sel  (pin_sel),
        .fs_q     (fs_latched),
        .mode_q   (mode_latched),
        .sel_q    (sel_24m)
    );

    fsel_mux u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (capture),
        .run         (running),
        .load_fs     (pin_fs),
        .hw_fs       (fs_latched),
        .sw_override (sw_override),
        .sw_index    (sw_index),
        .idx_q       (freq_index),
        .chg_q       (index_changed)
    );

    out_gate #(.N_OUT(N_OUT)) u_gate (
        .running (running),
        .tri_all (tristate_all),
        .enable  (out_enable),
        .run_o   (clk_run),
        .hiz_o   (clk_hiz)
    );
endmodule

// File: rtl/strap_fsel_chk.sv
module strap_fsel_chk
    import strap_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [FS_W-1:0]  pin_fs,
    input logic             pin_mode,
    input logic             pin_sel,
    input logic             sw_override,
    input logic [IDX_W-1:0] sw_index,
    input logic             tristate_all,
    input logic [N_OUT-1:0] out_enable,
    input logic             strap_sample,
    input logic [FS_W-1:0]  fs_latched,
    input logic             mode_latched,
    input logic             sel_24m,
    input logic [IDX_W-1:0] freq_index,
    input logic             index_changed,
    input logic [N_OUT-1:0] clk_run,
    input logic [N_OUT-1:0] clk_hiz
);
    AST_SAMPLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        strap_sample |=> !strap_sample); // R1
    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_sample |=> ($stable(fs_latched) && $stable(mode_latched) && $stable(sel_24m))); // R3
    AST_SW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_sample && $past(sw_override)) |-> (freq_index == $past(sw_index))); // R4
    AST_HW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_sample && !$past(sw_override)) |-> !freq_index[IDX_W-1]); // R5
    AST_TRI_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_sample && tristate_all) |-> (clk_run == '0 && (&clk_hiz))); // R7
    AST_CHG_REAL: assert property (@(posedge clk) disable iff (!rst_n)
        index_changed |-> (freq_index != $past(freq_index))); // R9
    AST_SAMPLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        strap_sample |-> (clk_run == '0 && clk_hiz == '0)); // R10
endmodule

bind strap_fsel strap_fsel_chk #(.N_OUT(N_OUT)) u_chk (.*);

// File: tb/tb_strap_fsel.sv
module tb_strap_fsel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pin_fs = 5'b0;
    logic       pin_mode = 1'b0;
    logic       pin_sel = 1'b0;
    logic       sw_override = 1'b0;
    logic [5:0] sw_index = 6'd0;
    logic       tristate_all = 1'b0;
    logic [7:0] out_enable = 8'hFF;
    logic       strap_sample;
    logic [4:0] fs_latched;
    logic       mode_latched;
    logic       sel_24m;
    logic [5:0] freq_index;
    logic       index_changed;
    logic [7:0] clk_run;
    logic [7:0] clk_hiz;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    strap_fsel dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic power_up(input logic [4:0] fs, input logic md, input logic sl);
        @(negedge clk);
        rst_n = 1'b0;
        pin_fs = fs; pin_mode = md; pin_sel = sl;
        @(negedge clk);
        chk(strap_sample == 1'b1, "R1 sample in reset", strap_sample, 1);
        chk(fs_latched == 5'b11001, "R2 default fs", fs_latched, 25);
        chk(mode_latched && sel_24m, "R2 default mode/sel", {mode_latched, sel_24m}, 3);
        chk(freq_index == 6'd25, "R2 default index", freq_index, 25);
        chk(clk_run == 8'h00 && clk_hiz == 8'h00, "R10 quiet", {clk_run, clk_hiz}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(strap_sample == 1'b0, "R1 capture done", strap_sample, 0);
        chk(fs_latched == fs, "R1 fs captured", fs_latched, fs);
        chk(mode_latched == md, "R6 mode", mode_latched, md);
        chk(sel_24m == sl, "R6 sel 24/48", sel_24m, sl);
        chk(freq_index == {1'b0, fs}, "R5 hw index", freq_index, {1'b0, fs});
        chk(index_changed == 1'b0, "R9 no strobe on capture", index_changed, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [5:0] prev;
        for (int f = 0; f < 32; f++) begin
            power_up(f[4:0], f[0] ^ f[3], f[2]);
        end
        power_up(5'b00110, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            pin_fs = 5'(k * 7 + 1); pin_mode = ~pin_mode; pin_sel = ~pin_sel;
            @(negedge clk);
            chk(fs_latched == 5'b00110 && !mode_latched && !sel_24m, "R3 pads ignored",
                {mode_latched, sel_24m, fs_latched}, 6);
            chk(freq_index == 6'd6 && !index_changed, "R3 index held", freq_index, 6);
        end
        prev = freq_index;
        sw_override = 1'b1;
        for (int i = 0; i < 64; i++) begin
            sw_index = 6'(63 - i);
            @(negedge clk);
            chk(freq_index == 6'(63 - i), "R4 sw index", freq_index, 63 - i);
            chk(index_changed == (prev != 6'(63 - i)), "R9 strobe", index_changed,
                int'(prev != 6'(63 - i)));
            prev = freq_index;
            @(negedge clk);
            chk(index_changed == 1'b0, "R9 one cycle", index_changed, 0);
        end
        sw_override = 1'b0;
        @(negedge clk);
        chk(freq_index == 6'd6 && index_changed, "R5 back to hw", freq_index, 6);
        for (int p = 0; p < 512; p++) begin
            out_enable = 8'(p);
            tristate_all = p[8];
            #1;
            if (p[8]) begin
                chk(clk_run == 8'h00, "R7 run off", clk_run, 0);
                chk(clk_hiz == 8'hFF, "R7 all hiz", clk_hiz, 255);
            end else begin
                chk(clk_run == 8'(p), "R8 run follows enable", clk_run, p);
                chk(clk_hiz == 8'h00, "R8 no hiz", clk_hiz, 0);
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule